// File: doc/BRIEF.md
# Processor-Driven Configuration Write Port

This block gives an embedded processor a direct path into a device's configuration memory through ordinary I/O writes. Software first loads three byte-wide address registers, which together select a 24-bit configuration location. A write to a separate data register then commits one byte to that location. On the system clock cycle after the data write, the block drives a single-cycle write strobe and a single-cycle configuration clock tick, together with the address and data, toward the configuration memory interface.

The path is write-only. Reads return zero, and the block offers no readback or compare of configuration contents. While the normal external configuration download is running, the port ignores every processor write, and a registered busy flag lets software poll for that state. An abort input abandons a transfer at any point. It cancels a write that would otherwise commit on the same clock edge and returns the address registers to zero. The processor-only reset cancels a pending write but keeps the loaded address, so a processor restart leaves the port's state in place. The chip-level reset clears everything.

Top module: `cfgw_port`

## Requirements
- R1: A synchronous chip reset (`rst` high) clears `cfg_we`, `cfg_clk`, `cfg_addr`, `cfg_data`, `busy` and all three address registers. The first data write after reset therefore targets address 0.
- R2: The address byte registers sit at I/O offsets IO_BASE+0, IO_BASE+1 and IO_BASE+2. They supply `cfg_addr` bits 7:0, 15:8 and 23:16 respectively. Each register holds its value until that same register is written again.
- R3: A write to the data register at IO_BASE+3 drives `cfg_we` and `cfg_clk` high for exactly one cycle, the cycle after the write, with `cfg_data` equal to the written byte. Data writes in consecutive cycles give strobes in consecutive cycles.
- R4: `cfg_addr` and `cfg_data` change only when a strobe is issued and hold between strobes. A write to an address register issues no strobe.
- R5: `io_rdata` is always zero; no register contents can be read back.
- R6: While `dl_active` is high, processor writes to any of the four registers are ignored. No strobe is issued and the address registers keep their values.
- R7: `busy` follows `dl_active` one cycle later.
- R8: `abort` high on the edge of a data write suppresses its strobe. On any edge where `abort` is high, all address registers are cleared to zero.
- R9: `cpu_rst` high on the edge of a data write suppresses its strobe but leaves the address registers unchanged.
- R10: Writes to I/O addresses outside IO_BASE..IO_BASE+3 issue no strobe and change no address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high chip reset |
| cpu_rst | input | 1 | Processor-only reset; cancels a pending write, keeps the address |
| io_we | input | 1 | Processor I/O write enable |
| io_addr | input | IO_AW | Processor I/O address |
| io_wdata | input | BYTE_W | Processor I/O write data |
| io_rdata | output | BYTE_W | Read data, constant zero |
| dl_active | input | 1 | Normal external configuration download in progress |
| abort | input | 1 | Abandon transfer: cancel strobe, clear address registers |
| busy | output | 1 | Registered download lockout flag |
| cfg_addr | output | BYTE_W*ADDR_BYTES | Configuration write address |
| cfg_data | output | BYTE_W | Configuration write data |
| cfg_we | output | 1 | One-cycle configuration write strobe |
| cfg_clk | output | 1 | One-tick configuration clock per data write |

## Verification
The bench builds the block with its default parameters: IO_AW=6, IO_BASE=0x20, BYTE_W=8 and ADDR_BYTES=3. This places the registers at I/O locations 0x20 to 0x23 and produces a full 24-bit address. With three distinct address bytes, a misplaced byte lane or a byte register that ignores its select shows up directly in `cfg_addr`. The neighbouring locations 0x24 and 0x00 are within reach for the out-of-window case. Back-to-back data writes, and writes that coincide with abort, processor reset or the download lockout, exercise each suppression path against the retained address.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int unsigned DEF_IO_AW      = 6;
  localparam int unsigned DEF_IO_BASE    = 32;
  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_ADDR_BYTES = 3;

  // True when an I/O address equals a register location.
  function automatic logic slot_hit(input logic [31:0] addr, input int unsigned loc);
    return addr == loc;
  endfunction
endpackage

// File: rtl/cfgw_decode.sv
module cfgw_decode #(
  parameter int unsigned IO_AW      = cfgw_pkg::DEF_IO_AW,
  parameter int unsigned IO_BASE    = cfgw_pkg::DEF_IO_BASE,
  parameter int unsigned ADDR_BYTES = cfgw_pkg::DEF_ADDR_BYTES
) (
  input  logic                  io_we,
  input  logic [IO_AW-1:0]      io_addr,
  input  logic                  lock,
  output logic [ADDR_BYTES-1:0] addr_sel,
  output logic                  data_sel
);
  localparam int unsigned DATA_LOC = IO_BASE + ADDR_BYTES;

  logic wr_ok;
  assign wr_ok = io_we && !lock;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sel
    assign addr_sel[i] = wr_ok && cfgw_pkg::slot_hit(32'(io_addr), IO_BASE + i);
  end

  assign data_sel = wr_ok && cfgw_pkg::slot_hit(32'(io_addr), DATA_LOC);
endmodule

// File: rtl/cfgw_addr_bank.sv
module cfgw_addr_bank #(
  parameter int unsigned BYTE_W     = cfgw_pkg::DEF_BYTE_W,
  parameter int unsigned ADDR_BYTES = cfgw_pkg::DEF_ADDR_BYTES,
  localparam int unsigned AW        = BYTE_W * ADDR_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [ADDR_BYTES-1:0] sel,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [AW-1:0]         addr_q
);
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] b_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        b_q <= '0;
      end else if (sel[i]) begin
        b_q <= wdata;
      end
    end
    assign addr_q[i*BYTE_W +: BYTE_W] = b_q;
  end

  // R8: an abort leaves every address byte at zero
  p_abort_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (addr_q == '0));

  // R6 / R9 / R10: without a select or clear the address is untouched
  p_addr_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && !clr) |=> $stable(addr_q));
endmodule

// File: rtl/cfgw_strobe.sv
module cfgw_strobe #(
  parameter int unsigned AW     = 24,
  parameter int unsigned BYTE_W = cfgw_pkg::DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              kill,
  input  logic [AW-1:0]     addr_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [AW-1:0]     cfg_addr,
  output logic [BYTE_W-1:0] cfg_data,
  output logic              cfg_we,
  output logic              cfg_clk
);
  logic commit;
  assign commit = fire && !kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_we   <= 1'b0;
      cfg_clk  <= 1'b0;
      cfg_addr <= '0;
      cfg_data <= '0;
    end else begin
      cfg_we  <= commit;
      cfg_clk <= commit;
      if (commit) begin
        cfg_addr <= addr_in;
        cfg_data <= data_in;
      end
    end
  end

  // R8 / R9: a cancelling input on the write edge leaves no tick
  p_kill_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!cfg_we && !cfg_clk));

  // R4: address and data hold whenever no strobe was issued
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |-> ($stable(cfg_addr) && $stable(cfg_data)));
endmodule

// File: rtl/cfgw_port.sv
module cfgw_port #(
  parameter int unsigned IO_AW      = cfgw_pkg::DEF_IO_AW,
  parameter int unsigned IO_BASE    = cfgw_pkg::DEF_IO_BASE,
  parameter int unsigned BYTE_W     = cfgw_pkg::DEF_BYTE_W,
  parameter int unsigned ADDR_BYTES = cfgw_pkg::DEF_ADDR_BYTES,
  localparam int unsigned CFG_AW    = BYTE_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rst,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  input  logic              dl_active,
  input  logic              abort,
  output logic              busy,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [BYTE_W-1:0] cfg_data,
  output logic              cfg_we,
  output logic              cfg_clk
);
  localparam int unsigned DATA_LOC = IO_BASE + ADDR_BYTES;

  logic [ADDR_BYTES-1:0] addr_sel;
  logic                  data_sel;
  logic [CFG_AW-1:0]     addr_q;

  // Write-only register window
  assign io_rdata = '0;

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= dl_active;
  end

  cfgw_decode #(
    .IO_AW(IO_AW), .IO_BASE(IO_BASE), .ADDR_BYTES(ADDR_BYTES)
  ) u_decode (
    .io_we(io_we), .io_addr(io_addr), .lock(dl_active),
    .addr_sel(addr_sel), .data_sel(data_sel)
  );

  cfgw_addr_bank #(
    .BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES)
  ) u_bank (
    .clk(clk), .rst(rst), .clr(abort),
    .sel(addr_sel), .wdata(io_wdata), .addr_q(addr_q)
  );

  cfgw_strobe #(
    .AW(CFG_AW), .BYTE_W(BYTE_W)
  ) u_strobe (
    .clk(clk), .rst(rst), .fire(data_sel), .kill(abort || cpu_rst),
    .addr_in(addr_q), .data_in(io_wdata),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cfg_we(cfg_we), .cfg_clk(cfg_clk)
  );

  // R6: no strobe follows a cycle with the download lockout active
  p_lockout_r6: assert property (@(posedge clk) disable iff (rst)
    dl_active |=> !cfg_we);

  // R7: busy reports the lockout in the next cycle
  p_busy_follow_r7: assert property (@(posedge clk) disable iff (rst)
    dl_active |=> busy);

  // R3: every strobe traces back to a data register write
  p_tick_cause_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> $past(io_we && (io_addr == IO_AW'(DATA_LOC))));

  // R9: processor reset alone keeps the loaded address
  p_cpu_rst_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rst && !abort && !io_we) |=> $stable(addr_q));
endmodule

// File: tb/cfgw_port_tb_top.sv
module cfgw_port_tb_top;
  logic        clk = 1'b0;
  logic        rst, cpu_rst, io_we, dl_active, abort;
  logic [5:0]  io_addr;
  logic [7:0]  io_wdata, io_rdata, cfg_data;
  logic [23:0] cfg_addr;
  logic        busy, cfg_we, cfg_clk;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfgw_port dut_i (
    .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dl_active(dl_active), .abort(abort),
    .busy(busy), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_we(cfg_we),
    .cfg_clk(cfg_clk)
  );

  localparam logic [5:0] A_X = 6'h20, A_Y = 6'h21, A_Z = 6'h22, A_D = 6'h23;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; outputs then show the write's effect.
  task automatic wr(logic [5:0] a, logic [7:0] d);
    io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "cfg_we after reset", cfg_we, 0);
    check("R1", "cfg_clk after reset", cfg_clk, 0);
    check("R1", "cfg_addr after reset", cfg_addr, 0);
    check("R1", "cfg_data after reset", cfg_data, 0);
    check("R1", "busy after reset", busy, 0);
    wr(A_D, 8'h5A);
    check("R1", "first write address", cfg_addr, 0);
    check("R3", "first write data", cfg_data, 8'h5A);
    @(negedge clk);
  endtask

  task automatic t_basic;
    wr(A_X, 8'h12);
    check("R4", "no strobe on X write", cfg_we, 0);
    wr(A_Y, 8'h34);
    wr(A_Z, 8'h56);
    check("R4", "no strobe on Z write", cfg_we, 0);
    check("R4", "addr held during address loads", cfg_addr, 0);
    wr(A_D, 8'hA5);
    check("R3", "cfg_we pulse", cfg_we, 1);
    check("R3", "cfg_clk pulse", cfg_clk, 1);
    check("R2", "assembled address", cfg_addr, 24'h563412);
    check("R3", "data byte", cfg_data, 8'hA5);
    check("R5", "rdata zero", io_rdata, 0);
    @(negedge clk);
    check("R3", "cfg_we one cycle", cfg_we, 0);
    check("R3", "cfg_clk one cycle", cfg_clk, 0);
    check("R4", "address holds", cfg_addr, 24'h563412);
    check("R4", "data holds", cfg_data, 8'hA5);
  endtask

  task automatic t_back_to_back;
    wr(A_D, 8'h01);
    check("R3", "first of pair strobe", cfg_we, 1);
    check("R3", "first of pair data", cfg_data, 8'h01);
    wr(A_D, 8'h02);
    check("R3", "second of pair strobe", cfg_clk, 1);
    check("R3", "second of pair data", cfg_data, 8'h02);
    @(negedge clk);
    check("R3", "pair ends", cfg_we, 0);
  endtask

  task automatic t_partial;
    wr(A_Y, 8'h99);
    wr(A_D, 8'hC3);
    check("R2", "only middle byte changes", cfg_addr, 24'h569912);
    check("R5", "rdata zero after writes", io_rdata, 0);
    @(negedge clk);
  endtask

  task automatic t_lock;
    dl_active = 1'b1;
    @(negedge clk);
    check("R7", "busy rises", busy, 1);
    wr(A_X, 8'hFF);
    check("R6", "locked X write no strobe", cfg_we, 0);
    wr(A_D, 8'h77);
    check("R6", "locked data write no strobe", cfg_we, 0);
    check("R6", "locked data not presented", cfg_data, 8'hC3);
    dl_active = 1'b0;
    @(negedge clk);
    check("R7", "busy falls", busy, 0);
    wr(A_D, 8'h33);
    check("R6", "X untouched by locked write", cfg_addr, 24'h569912);
    check("R6", "strobe after unlock", cfg_we, 1);
    @(negedge clk);
  endtask

  task automatic t_abort;
    wr(A_X, 8'h01);
    abort = 1'b1;
    wr(A_D, 8'h88);
    abort = 1'b0;
    check("R8", "aborted write no strobe", cfg_we, 0);
    check("R8", "aborted write no data", cfg_data, 8'h33);
    wr(A_D, 8'h66);
    check("R8", "address cleared by abort", cfg_addr, 0);
    check("R8", "write after abort data", cfg_data, 8'h66);
    @(negedge clk);
  endtask

  task automatic t_cpu_rst;
    wr(A_X, 8'h0A);
    wr(A_Y, 8'h0B);
    wr(A_Z, 8'h0C);
    cpu_rst = 1'b1;
    wr(A_D, 8'h99);
    cpu_rst = 1'b0;
    check("R9", "cpu reset suppresses tick", cfg_clk, 0);
    wr(A_D, 8'h44);
    check("R9", "address kept across cpu reset", cfg_addr, 24'h0C0B0A);
    check("R9", "data after cpu reset", cfg_data, 8'h44);
    @(negedge clk);
  endtask

  task automatic t_other;
    wr(6'h24, 8'hEE);
    check("R10", "no strobe at base+4", cfg_we, 0);
    wr(6'h00, 8'hDD);
    check("R10", "no strobe at 0x00", cfg_we, 0);
    wr(A_D, 8'h55);
    check("R10", "address unchanged by stray writes", cfg_addr, 24'h0C0B0A);
    @(negedge clk);
  endtask

  task automatic t_chip_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", "cfg_addr cleared by chip reset", cfg_addr, 0);
    check("R1", "cfg_data cleared by chip reset", cfg_data, 0);
    wr(A_D, 8'h11);
    check("R1", "address registers cleared", cfg_addr, 0);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rst = 1'b1; cpu_rst = 1'b0; io_we = 1'b0; dl_active = 1'b0; abort = 1'b0;
    io_addr = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_back_to_back();
    t_partial();
    t_lock();
    t_abort();
    t_cpu_rst();
    t_other();
    t_chip_reset();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule